// File: doc/BRIEF.md
# Pipelined Carry-Save Summation Tree

This block adds a large set of signed operands, such as the tap products of a wide FIR filter, and produces their exact sum. Each pipeline level groups its operands in threes and feeds every group to a 3:2 carry-save compressor. A compressor returns a sum vector and a carry vector, and the carry vector moves up one bit position. Up to two operands that do not fill a group are registered and passed on unchanged. Each level has a register, so no carry ripples through the tree. Once two vectors remain, one registered carry-propagate adder forms the result.

The caller presents all operands at once as one flat vector, together with a valid flag. The flag moves through the pipeline alongside the data, and the output flag marks the result of exactly one accepted operand set. A set can be presented on every cycle. The result path has no back-pressure: the consumer must take each result in the cycle it is flagged. For that reason the input side has no ready signal. Register stages load only while the flag they receive is high, so an idle cycle leaves the stored result where it is.

Top module: `csa_tree_sum`

## Requirements
- R1: While rst_n is low, and on the first sample after reset, sum_valid is 0 and sum_out is 0.
- R2: Every 3:2 compressor keeps the total. Its sum vector plus twice its carry vector equals the sum of its three inputs, modulo 2^SUM_W.
- R3: Each pipeline level passes on the same total, modulo 2^SUM_W, as the operand set it captured.
- R4: sum_out is the exact two's-complement sum of the NUM_OPS signed OP_W-bit operands. Operand i sits in in_ops[i*OP_W +: OP_W]. The result is SUM_W = OP_W + clog2(NUM_OPS) bits wide, so it cannot overflow, even with all operands at the most negative or most positive value.
- R5: The result of a set taken with in_valid high appears with sum_valid high exactly LEVELS+1 cycles later. LEVELS is the number of 3:2 levels needed to bring the operand count down to two, where each level turns n operands into 2*floor(n/3) + n mod 3. The default NUM_OPS = 16 gives 6 levels and a latency of 7. Each accepted set yields exactly one flagged result.
- R6: Sets presented on consecutive cycles come out on consecutive cycles, in order, with no bubbles.
- R7: A cycle with in_valid low changes no stored result. Whatever is on in_ops at that time, sum_valid stays low for it and sum_out holds its last value until the next flagged result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Marks in_ops as a set to be summed |
| in_ops | input | NUM_OPS*OP_W | Signed operands, operand i at bits i*OP_W +: OP_W |
| sum_valid | output | 1 | Marks sum_out as a new result |
| sum_out | output | SUM_W | Signed sum of one operand set |

## Verification
The bench derives the latency from the operand count by itself, repeating the level reduction n -> 2*floor(n/3) + n mod 3 until two operands remain, and adding one cycle for the final adder. Every set it presents goes into a queue together with the cycle count at which it was driven. Each time sum_valid is high, the oldest entry is removed and checked twice: its value against the bench's own signed sum, and its age against exactly LEVELS+1 cycles. Outputs are sampled on the falling edge, half a cycle after the register that drives them. After each scenario the bench waits for the pipeline to drain and confirms that no expected result is still outstanding.

// File: rtl/csa_tree_pkg.sv
`timescale 1ns/1ps
package csa_tree_pkg;

  // operands left after one 3:2 level
  function automatic int next_count(input int n);
    return 2 * (n / 3) + (n % 3);
  endfunction

  // number of compression levels until at most two operands remain
  function automatic int level_total(input int n);
    int m;
    int k;
    m = n;
    k = 0;
    while (m > 2) begin
      m = next_count(m);
      k++;
    end
    return k;
  endfunction

  // operand count after lvl levels
  function automatic int count_at(input int n, input int lvl);
    int m;
    m = n;
    for (int i = 0; i < lvl; i++) m = next_count(m);
    return m;
  endfunction

endpackage

// File: rtl/csa_compressor.sv
`timescale 1ns/1ps
module csa_compressor #(
  parameter int WIDTH = 12
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [WIDTH-1:0] c,
  output logic [WIDTH-1:0] s,
  output logic [WIDTH-1:0] cy
);

  assign s  = a ^ b ^ c;
  assign cy = (a & b) | (a & c) | (b & c);

  // R2: bitwise outputs keep the arithmetic total
  logic [WIDTH-1:0] lhs_chk;
  logic [WIDTH-1:0] rhs_chk;
  always_comb begin
    lhs_chk = s + {cy[WIDTH-2:0], 1'b0};
    rhs_chk = a + b + c;
    assert_compress_total_R2: assert (lhs_chk == rhs_chk)
      else $error("compressor total mismatch");
  end

endmodule

// File: rtl/csa_level.sv
`timescale 1ns/1ps
module csa_level
  import csa_tree_pkg::*;
#(
  parameter int WIDTH = 12,
  parameter int N_IN  = 16,
  localparam int N_OUT  = next_count(N_IN),
  localparam int GROUPS = N_IN / 3,
  localparam int SPARE  = N_IN % 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_IN*WIDTH-1:0]  din,
  input  logic                   vin,
  output logic [N_OUT*WIDTH-1:0] dout,
  output logic                   vout
);

  logic [WIDTH-1:0] nxt   [N_OUT];
  logic [WIDTH-1:0] held  [N_OUT];

  for (genvar g = 0; g < GROUPS; g++) begin : grp_g
    logic [WIDTH-1:0] s_w;
    logic [WIDTH-1:0] c_w;
    csa_compressor #(.WIDTH(WIDTH)) u_cmp (
      .a  (din[(3*g)*WIDTH   +: WIDTH]),
      .b  (din[(3*g+1)*WIDTH +: WIDTH]),
      .c  (din[(3*g+2)*WIDTH +: WIDTH]),
      .s  (s_w),
      .cy (c_w)
    );
    assign nxt[2*g]   = s_w;
    assign nxt[2*g+1] = {c_w[WIDTH-2:0], 1'b0};
  end

  for (genvar r = 0; r < SPARE; r++) begin : spare_g
    assign nxt[2*GROUPS+r] = din[(3*GROUPS+r)*WIDTH +: WIDTH];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vout <= 1'b0;
      for (int i = 0; i < N_OUT; i++) held[i] <= '0;
    end else begin
      vout <= vin;
      if (vin) begin
        for (int i = 0; i < N_OUT; i++) held[i] <= nxt[i];
      end
    end
  end

  for (genvar o = 0; o < N_OUT; o++) begin : out_g
    assign dout[o*WIDTH +: WIDTH] = held[o];
  end

  // R3: the registered level carries the captured total forward
  logic [WIDTH-1:0] in_total;
  logic [WIDTH-1:0] out_total;
  always_comb begin
    in_total = '0;
    for (int i = 0; i < N_IN; i++) in_total = in_total + din[i*WIDTH +: WIDTH];
    out_total = '0;
    for (int i = 0; i < N_OUT; i++) out_total = out_total + held[i];
  end

  assert_level_total_R3: assert property (@(posedge clk) disable iff (!rst_n)
    vin |=> (out_total == $past(in_total)))
    else $error("level total not preserved");

endmodule

// File: rtl/csa_final_add.sv
`timescale 1ns/1ps
module csa_final_add #(
  parameter int WIDTH = 12,
  parameter int N_IN  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N_IN*WIDTH-1:0] din,
  input  logic                  vin,
  output logic [WIDTH-1:0]      sum,
  output logic                  vout
);

  logic [WIDTH-1:0] total_w;

  if (N_IN == 2) begin : two_g
    assign total_w = din[WIDTH-1:0] + din[2*WIDTH-1:WIDTH];
  end else begin : one_g
    assign total_w = din[WIDTH-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sum  <= '0;
      vout <= 1'b0;
    end else begin
      vout <= vin;
      if (vin) sum <= total_w;
    end
  end

  // R7: a cycle without a flagged set leaves the result untouched
  assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !vin |=> $stable(sum))
    else $error("result changed without valid");

endmodule

// File: rtl/csa_tree_sum.sv
`timescale 1ns/1ps
module csa_tree_sum
  import csa_tree_pkg::*;
#(
  parameter int NUM_OPS = 16,
  parameter int OP_W    = 8,
  localparam int SUM_W    = OP_W + $clog2(NUM_OPS),
  localparam int LEVELS   = level_total(NUM_OPS),
  localparam int LAST_CNT = count_at(NUM_OPS, LEVELS),
  localparam int LATENCY  = LEVELS + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [NUM_OPS*OP_W-1:0] in_ops,
  output logic                    sum_valid,
  output logic [SUM_W-1:0]        sum_out
);

  // sign-extend every operand to the full result width
  logic [NUM_OPS*SUM_W-1:0] stage0;
  for (genvar i = 0; i < NUM_OPS; i++) begin : ext_g
    assign stage0[i*SUM_W +: SUM_W] =
      {{(SUM_W-OP_W){in_ops[i*OP_W+OP_W-1]}}, in_ops[i*OP_W +: OP_W]};
  end

  for (genvar k = 0; k < LEVELS; k++) begin : lvl_g
    localparam int CNT_IN  = count_at(NUM_OPS, k);
    localparam int CNT_OUT = count_at(NUM_OPS, k + 1);
    logic [CNT_IN*SUM_W-1:0]  d_in;
    logic                     v_in;
    logic [CNT_OUT*SUM_W-1:0] q;
    logic                     v;
    if (k == 0) begin : head_g
      assign d_in = stage0;
      assign v_in = in_valid;
    end else begin : link_g
      assign d_in = lvl_g[k-1].q;
      assign v_in = lvl_g[k-1].v;
    end
    csa_level #(.WIDTH(SUM_W), .N_IN(CNT_IN)) u_level (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (d_in),
      .vin  (v_in),
      .dout (q),
      .vout (v)
    );
  end

  logic [LAST_CNT*SUM_W-1:0] last_d;
  logic                      last_v;
  if (LEVELS == 0) begin : direct_g
    assign last_d = stage0;
    assign last_v = in_valid;
  end else begin : tail_g
    assign last_d = lvl_g[LEVELS-1].q;
    assign last_v = lvl_g[LEVELS-1].v;
  end

  csa_final_add #(.WIDTH(SUM_W), .N_IN(LAST_CNT)) u_final (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (last_d),
    .vin  (last_v),
    .sum  (sum_out),
    .vout (sum_valid)
  );

  // R5: flagged results never outnumber accepted sets nor lag beyond the pipe
  localparam int PW = $clog2(LATENCY + 2) + 1;
  logic [PW-1:0] pending;
  always_ff @(posedge clk) begin
    if (!rst_n) pending <= '0;
    else        pending <= pending + PW'(in_valid) - PW'(sum_valid);
  end

  assert_pending_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pending <= PW'(LATENCY))
    else $error("more sets in flight than pipeline depth");

  assert_no_orphan_result_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sum_valid |-> (pending != '0))
    else $error("result flagged without an accepted set");

endmodule

// File: tb/sim_csa_tree_sum.sv
`timescale 1ns/1ps
module sim_csa_tree_sum;

  localparam int N   = 16;
  localparam int W   = 8;
  localparam int SW  = W + $clog2(N);

  // latency from the reduction rule, worked out independently
  function automatic int bench_latency();
    int m;
    int k;
    m = N;
    k = 0;
    while (m > 2) begin
      m = 2 * (m / 3) + (m % 3);
      k++;
    end
    return k + 1;
  endfunction

  localparam int LAT = bench_latency();

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [N*W-1:0] in_ops = '0;
  logic sum_valid;
  logic [SW-1:0] sum_out;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic done = 1'b0;

  logic [SW-1:0] exp_q [$];
  int            stamp_q [$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  csa_tree_sum #(.NUM_OPS(N), .OP_W(W)) u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ops   (in_ops),
    .sum_valid(sum_valid),
    .sum_out  (sum_out)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [SW-1:0] ref_sum(input logic [N*W-1:0] v);
    longint acc;
    acc = 0;
    for (int i = 0; i < N; i++) acc += longint'($signed(v[i*W +: W]));
    return SW'(acc);
  endfunction

  function automatic logic [N*W-1:0] rand_set();
    logic [N*W-1:0] v;
    for (int i = 0; i < N; i++) v[i*W +: W] = W'($urandom);
    return v;
  endfunction

  // monitor: value and age of every flagged result
  always @(negedge clk) begin
    if (rst_n && sum_valid && !done) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R5 unexpected result", 1, 0);
      end else begin
        logic [SW-1:0] e;
        int st;
        e  = exp_q.pop_front();
        st = stamp_q.pop_front();
        check(sum_out == e, "R4 sum (R2 R3 totals)",
              longint'($signed(sum_out)), longint'($signed(e)));
        check((cyc - st) == LAT, "R5 latency", cyc - st, LAT);
      end
    end
  end

  task automatic send(input logic [N*W-1:0] v);
    @(negedge clk);
    in_valid = 1'b1;
    in_ops   = v;
    exp_q.push_back(ref_sum(v));
    stamp_q.push_back(cyc);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_ops   = rand_set();
    end
  endtask

  task automatic drain(input string req);
    idle(LAT + 2);
    check(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(sum_valid == 1'b0, "R1 valid in reset", sum_valid, 0);
    check(sum_out == '0, "R1 sum in reset", sum_out, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(sum_valid == 1'b0, "R1 valid after reset", sum_valid, 0);
    check(sum_out == '0, "R1 sum after reset", sum_out, 0);
  endtask

  task automatic t_impulse();
    logic [N*W-1:0] v;
    v = '0;
    v[5*W +: W] = W'(37);
    send(v);
    v = '0;
    v[(N-1)*W +: W] = W'(-100);
    send(v);
    v = '0;
    send(v);
    drain("R4 impulse drain");
  endtask

  task automatic t_extremes();
    logic [N*W-1:0] v;
    for (int i = 0; i < N; i++) v[i*W +: W] = {1'b0, {(W-1){1'b1}}};
    send(v);
    for (int i = 0; i < N; i++) v[i*W +: W] = {1'b1, {(W-1){1'b0}}};
    send(v);
    for (int i = 0; i < N; i++) v[i*W +: W] = (i % 2 == 0) ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
    send(v);
    drain("R4 extremes drain");
  endtask

  task automatic t_burst();
    for (int i = 0; i < 40; i++) send(rand_set());
    drain("R6 back-to-back drain");
  endtask

  task automatic t_gaps();
    for (int i = 0; i < 30; i++) begin
      send(rand_set());
      idle($urandom_range(0, 3));
    end
    drain("R5 gapped drain");
  endtask

  task automatic t_hold();
    logic [SW-1:0] last;
    send(rand_set());
    drain("R7 setup drain");
    last = sum_out;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_ops   = rand_set();
      check(sum_valid == 1'b0, "R7 valid stays low", sum_valid, 0);
      check(sum_out == last, "R7 sum held", longint'(sum_out), longint'(last));
    end
    send(rand_set());
    drain("R7 resume drain");
  endtask

  initial begin
    t_reset();
    t_impulse();
    t_extremes();
    t_burst();
    t_gaps();
    t_hold();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule